// File: doc/BRIEF.md
# Dual-Bank Floating-Point Register File

This block holds the floating-point register state for a processor pipeline. It has two physical banks of sixteen 32-bit registers. A bank-select mode bit decides which physical bank software sees as the front register set and which it sees as the back set. Every read and every transfer names a logical index plus a front/back select. The block turns that pair into a physical bank through the current mapping.

A 32-bit control word sets three mode bits: bank select, transfer size and precision. With a narrow transfer size, a move writes one 32-bit word. With a wide transfer size, a move writes an aligned register pair from a 64-bit operand. The block flags two cases and drops the write in both. The first is a move made while both the wide transfer size and the precision bit are set, which is a reserved setting. The second is a wide move to an odd index. The two read ports are combinational. Writes commit on the rising clock edge.

Top module: `fpbank_regfile`

## Requirements
- R1: After reset, the bank-select, transfer-size and precision mode bits all read 0. Register contents are undefined.
- R2: With bank select 0, front index n reads and writes physical bank 0 register n, and back index n uses physical bank 1 register n.
- R3: With bank select 1, the banks are swapped: front index n uses physical bank 1 and back index n uses physical bank 0.
- R4: With transfer size 0, a legal transfer writes bits 31:0 of the 64-bit operand into the one addressed register and leaves its neighbours unchanged.
- R5: With transfer size 1 and an even index n, bits 31:0 go to register n and bits 63:32 go to register n+1 in the addressed set.
- R6: When transfer size and precision are both 1, any transfer raises the illegal flag in that cycle and changes no register. The flag is never raised without a transfer request, and precision 1 with transfer size 0 is legal.
- R7: With transfer size 1, a transfer to an odd index raises the illegal flag and changes no register.
- R8: A control write loads bank select from bit 21, transfer size from bit 20 and precision from bit 19, and ignores bits 31:22 and 18:0. The new mode is visible in the next cycle. Reads and transfers in the cycle of the control write use the old mapping. Without a control write the mode holds.
- R9: Read ports return data combinationally. A read of the register being written in the same cycle returns the old value, and the new value appears from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word (bank 21, size 20, precision 19) |
| mode_bank | output | 1 | Current bank-select bit |
| mode_size | output | 1 | Current transfer-size bit |
| mode_prec | output | 1 | Current precision bit |
| xfer_we | input | 1 | Transfer (write) request |
| xfer_back | input | 1 | 0 = front set, 1 = back set |
| xfer_idx | input | 4 | Logical register index |
| xfer_wdata | input | 64 | Operand; low word first |
| xfer_illegal | output | 1 | Transfer rejected for mode or alignment |
| rda_back | input | 1 | Read port A set select |
| rda_idx | input | 4 | Read port A index |
| rda_data | output | 32 | Read port A data |
| rdb_back | input | 1 | Read port B set select |
| rdb_idx | input | 4 | Read port B index |
| rdb_data | output | 32 | Read port B data |

## Verification
A wrong mode register shows up one cycle after a control write. The mode outputs change, and reads of the same index through front and back swap their results or fail to swap. A wrong write decode corrupts a neighbour or the other bank. That damage stays hidden until the bench reads that exact register, so every register is filled with a distinct value and the neighbours of each write target are read back. A wrong legality check shows in the illegal flag in the same cycle, and a suppressed write that still commits shows in a read on the following cycle.

// File: rtl/fpbank_pkg.sv
package fpbank_pkg;
  localparam int unsigned CTL_W    = 32;
  localparam int unsigned BIT_BANK = 21;
  localparam int unsigned BIT_SIZE = 20;
  localparam int unsigned BIT_PREC = 19;
  localparam int unsigned NBANK    = 2;

  typedef struct packed {
    logic bank;
    logic size;
    logic prec;
  } mode_t;
endpackage

// File: rtl/fpb_rst_sync.sv
module fpb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/fpb_ctrl.sv
module fpb_ctrl
  import fpbank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output mode_t            mode_q
);
  mode_t mode_d;
  logic  field_unused;

  // reserved and out-of-scope fields are dropped
  assign field_unused = ^{wdata[CTL_W-1:BIT_BANK+1], wdata[BIT_PREC-1:0]};

  always_comb begin
    mode_d = mode_q;
    if (we) begin
      mode_d.bank = wdata[BIT_BANK];
      mode_d.size = wdata[BIT_SIZE];
      mode_d.prec = wdata[BIT_PREC];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_d;
  end
endmodule

// File: rtl/fpb_wdec.sv
module fpb_wdec
  import fpbank_pkg::*;
#(
  parameter int unsigned NREG = 16,
  localparam int unsigned IW  = $clog2(NREG)
) (
  input  mode_t                       mode,
  input  logic                        xfer_we,
  input  logic                        xfer_back,
  input  logic [IW-1:0]               xfer_idx,
  output logic                        illegal,
  output logic [NBANK-1:0][NREG-1:0]  bank_we
);
  logic          legal;
  logic          phys_sel;
  logic [IW-1:0] idx_hi;

  // reserved size/precision pair, or misaligned pair
  assign legal    = !(mode.size && mode.prec) && !(mode.size && xfer_idx[0]);
  assign illegal  = xfer_we && !legal;
  assign phys_sel = xfer_back ^ mode.bank;
  assign idx_hi   = {xfer_idx[IW-1:1], 1'b1};

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    for (genvar r = 0; r < NREG; r++) begin : g_reg
      localparam logic [IW-1:0] RIDX = IW'(r);
      logic hit;
      assign hit = (RIDX == xfer_idx) || (mode.size && (RIDX == idx_hi));
      assign bank_we[b][r] = xfer_we && legal && (phys_sel == b[0]) && hit;
    end
  end
endmodule

// File: rtl/fpb_bank.sv
module fpb_bank #(
  parameter int unsigned DW   = 32,
  parameter int unsigned NREG = 16,
  localparam int unsigned IW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic [NREG-1:0] we,
  input  logic            pair,
  input  logic [DW-1:0]   wd_lo,
  input  logic [DW-1:0]   wd_hi,
  input  logic [IW-1:0]   ra_idx,
  input  logic [IW-1:0]   rb_idx,
  output logic [DW-1:0]   ra_data,
  output logic [DW-1:0]   rb_data
);
  logic [DW-1:0] row [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_row
    localparam bit ODD = (r % 2) == 1;
    logic [DW-1:0] q;
    logic [DW-1:0] d;

    always_comb d = (pair && ODD) ? wd_hi : wd_lo;

    always_ff @(posedge clk) begin
      if (we[r]) q <= d;
    end

    assign row[r] = q;
  end

  assign ra_data = row[ra_idx];
  assign rb_data = row[rb_idx];
endmodule

// File: rtl/fpbank_regfile.sv
module fpbank_regfile
  import fpbank_pkg::*;
#(
  parameter int unsigned DW   = 32,
  parameter int unsigned NREG = 16,
  localparam int unsigned IW  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic              mode_bank,
  output logic              mode_size,
  output logic              mode_prec,
  input  logic              xfer_we,
  input  logic              xfer_back,
  input  logic [IW-1:0]     xfer_idx,
  input  logic [2*DW-1:0]   xfer_wdata,
  output logic              xfer_illegal,
  input  logic              rda_back,
  input  logic [IW-1:0]     rda_idx,
  output logic [DW-1:0]     rda_data,
  input  logic              rdb_back,
  input  logic [IW-1:0]     rdb_idx,
  output logic [DW-1:0]     rdb_data
);
  logic                       rst_n_sync;
  mode_t                      mode_q;
  logic [NBANK-1:0][NREG-1:0] bank_we;
  logic [DW-1:0]              ra_bank [NBANK];
  logic [DW-1:0]              rb_bank [NBANK];
  logic                       ra_phys;
  logic                       rb_phys;

  fpb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  fpb_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .we     (ctl_we),
    .wdata  (ctl_wdata),
    .mode_q (mode_q)
  );

  fpb_wdec #(.NREG(NREG)) u_wdec (
    .mode      (mode_q),
    .xfer_we   (xfer_we),
    .xfer_back (xfer_back),
    .xfer_idx  (xfer_idx),
    .illegal   (xfer_illegal),
    .bank_we   (bank_we)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    fpb_bank #(.DW(DW), .NREG(NREG)) u_bank (
      .clk     (clk),
      .we      (bank_we[b]),
      .pair    (mode_q.size),
      .wd_lo   (xfer_wdata[DW-1:0]),
      .wd_hi   (xfer_wdata[2*DW-1:DW]),
      .ra_idx  (rda_idx),
      .rb_idx  (rdb_idx),
      .ra_data (ra_bank[b]),
      .rb_data (rb_bank[b])
    );
  end

  // logical set plus bank select picks the physical bank
  assign ra_phys  = rda_back ^ mode_q.bank;
  assign rb_phys  = rdb_back ^ mode_q.bank;
  assign rda_data = ra_bank[ra_phys];
  assign rdb_data = rb_bank[rb_phys];

  assign mode_bank = mode_q.bank;
  assign mode_size = mode_q.size;
  assign mode_prec = mode_q.prec;
endmodule

// File: rtl/fpb_checker.sv
module fpb_checker #(
  parameter int unsigned DW   = 32,
  parameter int unsigned NREG = 16,
  localparam int unsigned IW  = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst_n_sync,
  input logic            ctl_we,
  input logic [31:0]     ctl_wdata,
  input logic            mode_bank,
  input logic            mode_size,
  input logic            mode_prec,
  input logic            xfer_we,
  input logic            xfer_back,
  input logic [IW-1:0]   xfer_idx,
  input logic [2*DW-1:0] xfer_wdata,
  input logic            xfer_illegal,
  input logic            rda_back,
  input logic [IW-1:0]   rda_idx,
  input logic [DW-1:0]   rda_data
);
  a_r6_reserved_flag: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (xfer_we && mode_size && mode_prec) |-> xfer_illegal);

  a_r6_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !xfer_we |-> !xfer_illegal);

  a_r7_odd_pair_flag: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (xfer_we && mode_size && xfer_idx[0]) |-> xfer_illegal);

  a_r8_mode_capture: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ctl_we |=> (mode_bank == $past(ctl_wdata[21])) && (mode_size == $past(ctl_wdata[20]))
               && (mode_prec == $past(ctl_wdata[19])));

  a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !ctl_we |=> $stable({mode_bank, mode_size, mode_prec}));

  a_r4_single_readback: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ($past(xfer_we && !xfer_illegal && !mode_size && !ctl_we)
     && (rda_idx == $past(xfer_idx)) && (rda_back == $past(xfer_back)))
    |-> (rda_data == $past(xfer_wdata[DW-1:0])));
endmodule

bind fpbank_regfile fpb_checker #(.DW(DW), .NREG(NREG)) u_chk (.*);

// File: tb/sim_fpbank_regfile.sv
module sim_fpbank_regfile;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_we;
  logic [31:0] ctl_wdata;
  logic        mode_bank, mode_size, mode_prec;
  logic        xfer_we, xfer_back;
  logic [3:0]  xfer_idx;
  logic [63:0] xfer_wdata;
  logic        xfer_illegal;
  logic        rda_back, rdb_back;
  logic [3:0]  rda_idx, rdb_idx;
  logic [31:0] rda_data, rdb_data;

  always #10 clk = ~clk;  // 50 MHz

  fpbank_regfile u0 (.*);

  typedef struct {
    int          kind;  // 0 port A, 1 port B, 2 illegal flag, 3 mode bits
    logic [31:0] exp;
    int          req;
  } item_t;

  item_t       sb[$];
  int          total = 0;
  int          bad = 0;
  bit          finished = 0;

  // reference model built from the requirements
  logic [31:0] mphys [2][16];
  bit          mvalid [2][16];
  bit          mfr, msz, mpr;

  function automatic logic [31:0] mread(bit back, int idx);
    return mphys[back ^ mfr][idx];
  endfunction

  // monitor: compare queued expectations mid-cycle
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t       it;
      logic [31:0] act;
      it = sb.pop_front();
      case (it.kind)
        0:       act = rda_data;
        1:       act = rdb_data;
        2:       act = {31'b0, xfer_illegal};
        default: act = {29'b0, mode_bank, mode_size, mode_prec};
      endcase
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL R%0d kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic push(int kind, logic [31:0] exp, int req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic chk_rd(bit port_b, bit back, int idx, int req);
    if (port_b) begin rdb_back = back; rdb_idx = idx[3:0]; end
    else        begin rda_back = back; rda_idx = idx[3:0]; end
    if (mvalid[back ^ mfr][idx]) push(port_b ? 1 : 0, mread(back, idx), req);
    tick();
  endtask

  // driver: one transfer; also reads the target in the same cycle (R9)
  task automatic do_xfer(bit back, int idx, logic [63:0] d);
    bit ill;
    int pb;
    ill = msz && (mpr || (idx % 2 == 1));
    xfer_we = 1'b1; xfer_back = back; xfer_idx = idx[3:0]; xfer_wdata = d;
    rda_back = back; rda_idx = idx[3:0];
    push(2, {31'b0, ill}, mpr && msz ? 6 : 7);
    if (mvalid[back ^ mfr][idx]) push(0, mread(back, idx), 9);  // R9 old value
    tick();
    xfer_we = 1'b0;
    if (!ill) begin
      pb = back ^ mfr;
      mphys[pb][idx] = d[31:0]; mvalid[pb][idx] = 1'b1;
      if (msz) begin mphys[pb][idx+1] = d[63:32]; mvalid[pb][idx+1] = 1'b1; end
    end
  endtask

  // driver: control write; same-cycle read uses old mapping (R8)
  task automatic do_ctl(logic [31:0] w);
    ctl_we = 1'b1; ctl_wdata = w;
    rdb_back = 1'b0; rdb_idx = 4'd3;
    if (mvalid[mfr][3]) push(1, mread(1'b0, 3), 8);
    tick();
    ctl_we = 1'b0;
    mfr = w[21]; msz = w[20]; mpr = w[19];
    push(3, {29'b0, mfr, msz, mpr}, 8);  // R8 bit positions
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ctl_we = 0; ctl_wdata = '0; xfer_we = 0; xfer_back = 0;
    xfer_idx = '0; xfer_wdata = '0; rda_back = 0; rdb_back = 0; rda_idx = '0; rdb_idx = '0;
    mfr = 0; msz = 0; mpr = 0;
    for (int b = 0; b < 2; b++) for (int i = 0; i < 16; i++) mvalid[b][i] = 1'b0;
    repeat (3) @(posedge clk); #2;
    rst_n = 1'b1;
    repeat (3) tick();
    push(3, 32'd0, 1);  // R1 reset mode bits
    tick();

    // R2: fill through front and back with bank select 0
    for (int i = 0; i < 16; i++) do_xfer(1'b0, i, {32'hFFFF_FFFF, 32'hA000_0000 | i});
    for (int i = 0; i < 16; i++) do_xfer(1'b1, i, {32'hEEEE_EEEE, 32'hB000_0000 | i});
    chk_rd(0, 0, 0, 2);  push(0, 32'hA000_0000, 2); tick();
    chk_rd(1, 1, 15, 2); push(1, 32'hB000_000F, 2); tick();
    chk_rd(0, 1, 5, 2);
    // R4 with R2: single move left neighbours intact, high word unused
    chk_rd(1, 0, 1, 4);

    // R8: reserved bits set; bank select 1
    do_ctl(32'hFFC0_0000 | (32'd1 << 21) | 32'h0007_FFFF);
    // R3: swapped mapping
    chk_rd(0, 0, 5, 3);  push(0, 32'hB000_0005, 3); tick();
    chk_rd(1, 1, 5, 3);  push(1, 32'hA000_0005, 3); tick();

    // R4: single write in swapped mapping, then neighbours
    do_xfer(1'b0, 7, 64'hDEAD_BEEF_1234_5678);
    chk_rd(0, 0, 7, 4); push(0, 32'h1234_5678, 4); tick();
    chk_rd(1, 0, 6, 4); chk_rd(1, 0, 8, 4); chk_rd(0, 1, 7, 4);
    // R9: overwrite same register, old value seen in write cycle
    do_xfer(1'b0, 7, 64'h0000_0000_CAFE_F00D);
    chk_rd(0, 0, 7, 9);

    // R5: pair mode, bank select 1, back set index 4
    do_ctl(32'h0030_0000);
    do_xfer(1'b1, 4, 64'h5555_6666_7777_8888);
    chk_rd(0, 1, 4, 5); push(0, 32'h7777_8888, 5); tick();
    chk_rd(1, 1, 5, 5); push(1, 32'h5555_6666, 5); tick();
    chk_rd(0, 1, 6, 5); chk_rd(1, 0, 4, 5);

    // R7: odd index pair rejected
    do_xfer(1'b0, 9, 64'h1111_1111_2222_2222);
    chk_rd(0, 0, 9, 7); chk_rd(1, 0, 10, 7); chk_rd(0, 0, 8, 7);

    // R6: size and precision both set, rejected
    do_ctl(32'h0038_0000);
    do_xfer(1'b0, 2, 64'h9999_9999_9999_9999);
    chk_rd(0, 0, 2, 6); chk_rd(1, 0, 3, 6);
    // R6: precision alone is legal single move
    do_ctl(32'h0028_0000);
    do_xfer(1'b0, 3, 64'h0000_0000_ABCD_0003);
    chk_rd(1, 0, 3, 6); push(1, 32'hABCD_0003, 6); tick();

    // R2: back to bank select 0
    do_ctl(32'h0000_0000);
    chk_rd(0, 0, 3, 2); chk_rd(1, 1, 3, 2); chk_rd(0, 0, 4, 2); chk_rd(1, 1, 7, 2);

    tick();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule